// File: doc/BRIEF.md
# Cascadable Serial-Load LED Channel Controller

This block converts a serial bit stream into on/off controls for a bank of LED channels. Each rising edge of the shift clock takes one bit from the serial input into the first stage of a shift register, and every other stage moves one place toward the last stage. A level-sensitive hold latch sits between the register and the channel outputs. While the latch input is high, the outputs track the register. While it is low, they keep their last value. This lets a host load a whole new pattern and then show it in one step.

The last register stage leaves the block on a serial output that changes on the falling edge of the shift clock. The next device in a chain samples it on its own rising edge, so two chained devices behave like one longer register. Several conditions force every channel off without changing the stored pattern: a high output-disable input, a supply-undervoltage flag and an over-temperature flag. When the condition clears, the stored pattern shows again. An active-low asynchronous reset clears the register, the latch, the serial output and all channels.

The serial path is a plain shift-clock interface, not a valid/ready stream. There is no back-pressure: every rising edge of the shift clock consumes one bit, and the host controls the rate by how it drives that clock.

Top module: `led_chain_driver`

## Requirements
- R1: On each rising edge of `sck`, `sdi` enters stage 1 and each stage k takes the old value of stage k-1. Stage k maps to `ch_on[k-1]`.
- R2: `sdo` equals the value of the last stage (stage NUM_CH). It is updated only on the falling edge of `sck`.
- R3: While `latch_en` is high, the latch is transparent. The outputs follow the shift register and change whenever it shifts.
- R4: While `latch_en` is low, the latched pattern does not change, even if the shift register keeps shifting.
- R5: A latched bit of 1 turns its channel on. While `out_dis` is high, all channels are 0. When `out_dis` returns low, the latched pattern drives the channels again.
- R6: While `uv_flag` or `ot_flag` is high, all channels are 0. The stored pattern is kept, and it reappears when both flags are low.
- R7: While `rst_n` is low, the register, the latch, `sdo` and all channels are 0, whatever the state of `sck`.
- R8: When the `sdo` of one device drives the `sdi` of a second device, and 2*NUM_CH bits are shifted in and then latched, the second device holds the first NUM_CH bits and the first device holds the last NUM_CH bits. The most recent bit is in stage 1 of the first device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Shift clock; rising edge shifts, falling edge updates `sdo` |
| rst_n | input | 1 | Asynchronous active-low clear |
| sdi | input | 1 | Serial data in |
| latch_en | input | 1 | High: latch transparent; low: latch holds |
| out_dis | input | 1 | High forces all channels off |
| uv_flag | input | 1 | Supply-undervoltage flag; high forces all channels off |
| ot_flag | input | 1 | Over-temperature flag; high forces all channels off |
| sdo | output | 1 | Cascade output carrying the last stage |
| ch_on | output | NUM_CH | Per-channel on control; bit k-1 is stage k |

## Verification
The assertions assume that `sdi`, `latch_en`, `out_dis` and the fault flags are steady at each rising edge of `sck`. They also assume that `rst_n` changes only while `sck` is low, away from any edge. The bench drives new serial bits just after each falling edge. It raises and lowers `latch_en` in the low half-period, or holds it high across whole cycles. It changes the disable and fault inputs only in the low half-period. The assertions disable themselves during reset.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  localparam int unsigned LED_CH_DEFAULT = 24;

  // Conditions that blank every channel without touching stored state
  typedef struct packed {
    logic dis;
    logic uv;
    logic ot;
  } blank_req_t;
endpackage

// File: rtl/led_shift_reg.sv
module led_shift_reg #(
  parameter int unsigned NUM_CH = 24
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              sdi,
  output logic [NUM_CH-1:0] stages,
  output logic              sdo
);
  localparam int unsigned LAST = NUM_CH - 1;

  logic [NUM_CH:0] chain;
  assign chain[0] = sdi;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_stage
    always_ff @(posedge sck or negedge rst_n) begin
      if (!rst_n) chain[k+1] <= 1'b0;
      else        chain[k+1] <= chain[k];
    end
  end

  assign stages = chain[NUM_CH:1];

  // Cascade output retimed on the falling edge for hold margin downstream
  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) sdo <= 1'b0;
    else        sdo <= stages[LAST];
  end
endmodule

// File: rtl/led_hold_latch.sv
module led_hold_latch #(
  parameter int unsigned NUM_CH = 24
) (
  input  logic              rst_n,
  input  logic              le,
  input  logic [NUM_CH-1:0] d,
  output logic [NUM_CH-1:0] q
);
  always_latch begin
    if (!rst_n)  q = '0;
    else if (le) q = d;
  end
endmodule

// File: rtl/led_out_gate.sv
module led_out_gate
  import led_drv_pkg::*;
#(
  parameter int unsigned NUM_CH = 24
) (
  input  logic              rst_n,
  input  blank_req_t        req,
  input  logic [NUM_CH-1:0] lat,
  output logic [NUM_CH-1:0] ch_on
);
  logic pass;
  assign pass  = rst_n & ~req.dis & ~req.uv & ~req.ot;
  assign ch_on = lat & {NUM_CH{pass}};
endmodule

// File: rtl/led_chain_driver.sv
module led_chain_driver
  import led_drv_pkg::*;
#(
  parameter int unsigned NUM_CH = LED_CH_DEFAULT
) (
  input  logic              sck,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              latch_en,
  input  logic              out_dis,
  input  logic              uv_flag,
  input  logic              ot_flag,
  output logic              sdo,
  output logic [NUM_CH-1:0] ch_on
);
  logic [NUM_CH-1:0] sr_q;
  logic [NUM_CH-1:0] lat_q;
  blank_req_t        blank;

  assign blank = '{dis: out_dis, uv: uv_flag, ot: ot_flag};

  led_shift_reg #(.NUM_CH(NUM_CH)) u_sr (
    .sck    (sck),
    .rst_n  (rst_n),
    .sdi    (sdi),
    .stages (sr_q),
    .sdo    (sdo)
  );

  led_hold_latch #(.NUM_CH(NUM_CH)) u_lat (
    .rst_n (rst_n),
    .le    (latch_en),
    .d     (sr_q),
    .q     (lat_q)
  );

  led_out_gate #(.NUM_CH(NUM_CH)) u_gate (
    .rst_n (rst_n),
    .req   (blank),
    .lat   (lat_q),
    .ch_on (ch_on)
  );
endmodule

// File: rtl/led_chain_driver_chk.sv
module led_chain_driver_chk #(
  parameter int unsigned NUM_CH = 24
) (
  input logic              sck,
  input logic              rst_n,
  input logic              sdi,
  input logic              latch_en,
  input logic              out_dis,
  input logic              uv_flag,
  input logic              ot_flag,
  input logic              sdo,
  input logic [NUM_CH-1:0] ch_on,
  input logic [NUM_CH-1:0] sr_q,
  input logic [NUM_CH-1:0] lat_q
);
  // R1: one-place shift per rising edge
  a_r1_shift: assert property (@(posedge sck) disable iff (!rst_n)
    1'b1 |=> (sr_q[NUM_CH-1:1] == $past(sr_q[NUM_CH-2:0])) && (sr_q[0] == $past(sdi)));

  // R2: cascade output carries last stage, moved at falling edge
  a_r2_sdo_fall: assert property (@(negedge sck) disable iff (!rst_n)
    1'b1 |=> sdo == $past(sr_q[NUM_CH-1]));

  // R3: transparent latch tracks register
  a_r3_follow: assert property (@(posedge sck) disable iff (!rst_n)
    latch_en |-> lat_q == sr_q);

  // R5: disable blanks all channels
  a_r5_dis_off: assert property (@(posedge sck) disable iff (!rst_n)
    out_dis |-> ch_on == '0);

  // R6: fault flags blank all channels
  a_r6_fault_off: assert property (@(posedge sck) disable iff (!rst_n)
    (uv_flag || ot_flag) |-> ch_on == '0);
endmodule

bind led_chain_driver led_chain_driver_chk #(.NUM_CH(NUM_CH)) u_chk (
  .sck      (sck),
  .rst_n    (rst_n),
  .sdi      (sdi),
  .latch_en (latch_en),
  .out_dis  (out_dis),
  .uv_flag  (uv_flag),
  .ot_flag  (ot_flag),
  .sdo      (sdo),
  .ch_on    (ch_on),
  .sr_q     (sr_q),
  .lat_q    (lat_q)
);

// File: tb/led_chain_driver_bench.sv
module led_chain_driver_bench;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n, sdi, latch_en, out_dis, uv_flag, ot_flag;
  logic sdo_a, sdo_b;
  logic [N-1:0] ch_a, ch_b;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  // upstream device
  led_chain_driver #(.NUM_CH(N)) u_led_chain_driver (
    .sck(clk), .rst_n(rst_n), .sdi(sdi), .latch_en(latch_en), .out_dis(out_dis),
    .uv_flag(uv_flag), .ot_flag(ot_flag), .sdo(sdo_a), .ch_on(ch_a));

  // downstream device fed from the cascade output
  led_chain_driver #(.NUM_CH(N)) u_down (
    .sck(clk), .rst_n(rst_n), .sdi(sdo_a), .latch_en(latch_en), .out_dis(out_dis),
    .uv_flag(uv_flag), .ot_flag(ot_flag), .sdo(sdo_b), .ch_on(ch_b));

  // History of bits sent; hist[0] is the most recent
  logic [2*N-1:0] hist;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[2*N-2:0], sdi};
  end

  logic [N-1:0] lat_a, lat_b;

  function automatic logic [N-1:0] gated(input logic [N-1:0] lat);
    return (rst_n && !out_dis && !uv_flag && !ot_flag) ? lat : '0;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // new bit just after the falling edge, then settle 5 ns
  task automatic step();
    @(negedge clk);
    sdi = 1'($urandom);
    #5;
  endtask

  // latch pulse inside the low half-period
  task automatic pulse();
    latch_en = 1'b1;
    #1;
    lat_a = hist[N-1:0];
    lat_b = hist[2*N-1:N];
    latch_en = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] prev;
    logic         last_bit;
    void'($urandom(32'd1234));
    rst_n = 1'b0; sdi = 1'b0; latch_en = 1'b0; out_dis = 1'b0;
    uv_flag = 1'b0; ot_flag = 1'b0;
    lat_a = '0; lat_b = '0;

    repeat (3) step();
    chk("R7 reset ch A", ch_a, '0);
    chk("R7 reset ch B", ch_b, '0);
    chk("R7 reset sdo", {23'd0, sdo_a | sdo_b}, '0);
    #1 rst_n = 1'b1;

    // 48 bits with latch closed: cascade output and held latch
    for (int i = 0; i < 2 * N; i++) begin
      step();
      chk("R2 sdo A", {23'd0, sdo_a}, {23'd0, hist[N-1]});
      chk("R2 sdo B", {23'd0, sdo_b}, {23'd0, hist[2*N-1]});
      chk("R4 held A", ch_a, '0);
    end

    // R8: chained load of 48 bits, then latch
    pulse();
    chk("R8 chain A", ch_a, hist[N-1:0]);
    chk("R8 chain B", ch_b, hist[2*N-1:N]);

    // R4: keep shifting, latch stays
    repeat (6) begin
      step();
      chk("R4 hold A", ch_a, lat_a);
      chk("R4 hold B", ch_b, lat_b);
    end

    // R3/R1: transparent latch across edges
    step();
    latch_en = 1'b1;
    #1;
    prev = ch_a;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk);
      last_bit = sdi;
      @(negedge clk);
      sdi = 1'($urandom);
      #5;
      chk("R3 follow A", ch_a, hist[N-1:0]);
      chk("R3 follow B", ch_b, hist[2*N-1:N]);
      chk("R1 shift", ch_a, {prev[N-2:0], last_bit});
      prev = ch_a;
    end
    #1 latch_en = 1'b0;
    lat_a = hist[N-1:0];
    lat_b = hist[2*N-1:N];

    // R5: disable blanks, pattern returns
    step();
    out_dis = 1'b1; #1;
    chk("R5 dis A", ch_a, '0);
    chk("R5 dis B", ch_b, '0);
    step();
    chk("R5 dis held", ch_a, '0);
    out_dis = 1'b0; #1;
    chk("R5 re-enable A", ch_a, lat_a);
    chk("R5 re-enable B", ch_b, lat_b);

    // R6: each fault blanks and preserves
    step();
    uv_flag = 1'b1; #1;
    chk("R6 uv off", ch_a | ch_b, '0);
    step();
    uv_flag = 1'b0; #1;
    chk("R6 uv restore", ch_a, lat_a);
    ot_flag = 1'b1; #1;
    chk("R6 ot off", ch_a | ch_b, '0);
    step();
    ot_flag = 1'b0; #1;
    chk("R6 ot restore", ch_b, lat_b);

    // Random mix
    for (int r = 0; r < 40; r++) begin
      int n_steps;
      n_steps = 1 + int'($urandom % 30);
      repeat (n_steps) step();
      if ($urandom % 2 == 0) pulse();
      out_dis = ($urandom % 4) == 0;
      uv_flag = ($urandom % 4) == 0;
      ot_flag = ($urandom % 4) == 0;
      #1;
      chk("R5/R6 random A", ch_a, gated(lat_a));
      chk("R8 random B", ch_b, gated(lat_b));
      out_dis = 1'b0; uv_flag = 1'b0; ot_flag = 1'b0;
      #1;
      chk("R6 random restore", ch_a, lat_a);
    end

    // R7: asynchronous reset mid-run
    step();
    rst_n = 1'b0; #1;
    chk("R7 async A", ch_a, '0);
    chk("R7 async B", ch_b, '0);
    chk("R7 async sdo", {23'd0, sdo_a | sdo_b}, '0);
    lat_a = '0; lat_b = '0;
    step();
    rst_n = 1'b1; #1;
    chk("R7 latch cleared", ch_a | ch_b, '0);
    repeat (5) step();
    pulse();
    chk("R7 after reset A", ch_a, hist[N-1:0]);
    chk("R7 after reset B", ch_b, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule